// File: doc/BRIEF.md
# Supply Limit Window Checker

This block watches the sampled rails and the die temperature of a supply supervisor. Each of eleven channels has four 16-bit limit words. Two are under-limits and two are over-limits. Each word holds a 10-bit threshold and four action bits. When a sample arrives, the block compares it against the four limits of its channel. The action bits of every limit that the sample violates drive four request outputs: reset, power-off, shutdown, and the release of the healthy signal.

A violated limit is critical when it carries a reset, power-off or shutdown action. A critical violation latches a fault bit for its channel into a 16-bit status word. The host reads that word as two bytes and clears bits by writing ones to them. The temperature channel holds a two's-complement code in quarter-degree steps. Every other channel holds an unsigned code.

A small two-state machine sequences each sample. In state IDLE the block waits. A strobe with a valid channel index captures the sample and moves the machine to EVAL (transition "capture"). A strobe with an index of eleven or more is dropped, and the machine stays in IDLE (transition "drop"). In EVAL the compare result is committed. The machine then returns to IDLE, or it stays in EVAL if a further valid strobe arrives in the same cycle (transition "chain").

Top module: `supply_limit_cmp`

## Requirements
- R1: After reset, req_reset, req_poweroff and req_shutdown are 0 and healthy is 1. Every limit byte and both status bytes read 0.
- R2: With reg_stat_sel=0, the high byte of limit k (k = 0..3) of channel c is at byte address 0x80 + 8c + 2k and the low byte is at the next address. Limits 0 and 1 are under-limits and limits 2 and 3 are over-limits. Written bytes read back unchanged, and addresses outside 0x80..0xD7 read 0.
- R3: An under-limit is violated only when the sample is strictly below its threshold (word bits 9:0). An over-limit is violated only when the sample is strictly above it. Equality is not a violation.
- R4: Channel 8 compares sample and threshold as 10-bit two's-complement values, so codes 512..1023 are negative. All other channels compare unsigned.
- R5: req_reset, req_poweroff and req_shutdown are the OR of word bits 15, 13 and 12 over the limits violated by the most recent sample of every channel. A new sample on a channel replaces that channel's contribution.
- R6: healthy is 0 while any limit violated by a channel's most recent sample has bit 14 set.
- R7: A violation of a limit with bit 15, 13 or 12 set sets fault bit c (c = channel) of the status word. A violation of a limit with only bit 14 set leaves the status word unchanged.
- R8: Fault bits stay set until cleared. With reg_stat_sel=1, writing to address 0x81 clears the status bits 15:8 at the positions of the written ones. Writing to 0x82 does the same for bits 7:0. Reads of 0x81 and 0x82 return those two bytes. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: A sample strobed at clock edge k changes the outputs and the status word at edge k+1 and not before.
- R10: A strobe with a channel index of 11 or more changes no output and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 4 | Channel index of the sample |
| smp_code | input | 10 | Sample code |
| reg_we | input | 1 | Byte write enable |
| reg_stat_sel | input | 1 | 0 selects the limit space, 1 selects the status space |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| req_reset | output | 1 | Reset request |
| req_poweroff | output | 1 | Power-off request |
| req_shutdown | output | 1 | Shutdown request |
| healthy | output | 1 | Rails healthy, low on a bit-14 violation |

## Verification
The hardest case to reach from the ports is a host clear that lands in the same cycle as a fault set on the same bit. The clear is a write, while the set only happens one edge after the sample strobe. To produce the collision, the bench raises the sample strobe, then issues the clearing write on the very next cycle, so both reach the status register at the same edge. The bench also exercises the signed temperature compare. It picks codes that give the opposite verdict when read as unsigned, so a missing sign conversion shows up as the wrong request output.

// File: rtl/slc_pkg.sv
package slc_pkg;
    localparam int          LIM_PER_CH  = 4;
    localparam int          THR_W       = 10;
    localparam logic [7:0]  LIM_BASE    = 8'h80;
    localparam logic [7:0]  STAT_HI     = 8'h81;
    localparam logic [7:0]  STAT_LO     = 8'h82;
    localparam int          BIT_RST     = 15;
    localparam int          BIT_HLTH    = 14;
    localparam int          BIT_POFF    = 13;
    localparam int          BIT_SHDN    = 12;

    // request vector order: {reset, healthy-drop, poweroff, shutdown}
    typedef struct packed {
        logic rst;
        logic hlth;
        logic poff;
        logic shdn;
    } trig_t;

    typedef enum logic {ST_IDLE, ST_EVAL} seq_st_t;
endpackage

// File: rtl/slc_limit_bank.sv
module slc_limit_bank
    import slc_pkg::*;
#(
    parameter int N_CHAN = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [7:0]                        addr,
    input  logic [7:0]                        wdata,
    output logic [7:0]                        rdata,
    output logic [N_CHAN*LIM_PER_CH-1:0][15:0] words
);
    localparam int NW = N_CHAN * LIM_PER_CH;

    logic [7:0] off;
    logic       in_rng;
    logic [6:0] widx;

    assign off    = addr - LIM_BASE;
    assign widx   = off[7:1];
    assign in_rng = (addr >= LIM_BASE) && (int'(off) < NW * 2);

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (wr_en && in_rng && (int'(widx) == w)) begin
                if (off[0]) words[w][7:0]  <= wdata;
                else        words[w][15:8] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (in_rng && (int'(widx) == w))
                rdata = off[0] ? words[w][7:0] : words[w][15:8];
        end
    end

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words)); // R2
endmodule

// File: rtl/slc_window_cmp.sv
module slc_window_cmp
    import slc_pkg::*;
(
    input  logic                        is_temp,
    input  logic [THR_W-1:0]            code,
    input  logic [LIM_PER_CH-1:0][15:0] lims,
    output trig_t                       trig,
    output logic                        crit
);
    logic [THR_W-1:0]      key_s;
    logic [LIM_PER_CH-1:0] viol;

    // offset-binary key makes signed order match unsigned order
    assign key_s = is_temp ? {~code[THR_W-1], code[THR_W-2:0]} : code;

    for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_lim
        logic [THR_W-1:0] thr, key_t;
        assign thr   = lims[k][THR_W-1:0];
        assign key_t = is_temp ? {~thr[THR_W-1], thr[THR_W-2:0]} : thr;
        if (k < LIM_PER_CH / 2) begin : g_under
            assign viol[k] = key_s < key_t;
        end else begin : g_over
            assign viol[k] = key_s > key_t;
        end
    end

    always_comb begin
        trig = '0;
        crit = 1'b0;
        for (int k = 0; k < LIM_PER_CH; k++) begin
            if (viol[k]) begin
                trig.rst  = trig.rst  | lims[k][BIT_RST];
                trig.hlth = trig.hlth | lims[k][BIT_HLTH];
                trig.poff = trig.poff | lims[k][BIT_POFF];
                trig.shdn = trig.shdn | lims[k][BIT_SHDN];
                crit = crit | lims[k][BIT_RST] | lims[k][BIT_POFF] | lims[k][BIT_SHDN];
            end
        end
    end
endmodule

// File: rtl/slc_fault_track.sv
module slc_fault_track
    import slc_pkg::*;
#(
    parameter int N_CHAN = 11,
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_en,
    input  logic [CHAN_W-1:0] chan,
    input  trig_t             trig,
    input  logic              crit,
    input  logic [15:0]       clr_mask,
    output logic [15:0]       fault,
    output trig_t             req
);
    trig_t       held [N_CHAN];
    logic [15:0] set_mask;

    always_comb begin
        set_mask = '0;
        for (int c = 0; c < N_CHAN; c++)
            if (eval_en && crit && (chan == CHAN_W'(c))) set_mask[c] = 1'b1;
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)                                 held[c] <= '0;
            else if (eval_en && (chan == CHAN_W'(c)))   held[c] <= trig;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault <= '0;
        else        fault <= (fault & ~clr_mask) | set_mask;
    end

    always_comb begin
        req = '0;
        for (int c = 0; c < N_CHAN; c++) req = req | held[c];
    end

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == 16'h0) |=> ((fault & $past(fault)) == $past(fault))); // R8
    AST_FAULT_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !(eval_en && crit) |=> ((fault & ~$past(fault)) == 16'h0)); // R7
endmodule

// File: rtl/supply_limit_cmp.sv
module supply_limit_cmp
    import slc_pkg::*;
#(
    parameter int N_CHAN    = 11,
    parameter int CHAN_W    = 4,
    parameter int TEMP_CHAN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [9:0]        smp_code,
    input  logic              reg_we,
    input  logic              reg_stat_sel,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              req_reset,
    output logic              req_poweroff,
    output logic              req_shutdown,
    output logic              healthy
);
    localparam int NW = N_CHAN * LIM_PER_CH;

    seq_st_t            st_q, st_d;
    logic               take, eval_en;
    logic [CHAN_W-1:0]  cap_chan;
    logic [THR_W-1:0]   cap_code;
    logic [NW-1:0][15:0]          words;
    logic [LIM_PER_CH-1:0][15:0]  ch_lims;
    logic [7:0]         lim_rdata;
    logic [15:0]        fault, clr_mask;
    trig_t              trig, req;
    logic               crit;

    assign take = smp_valid && (int'(smp_chan) < N_CHAN);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = take ? ST_EVAL : ST_IDLE;  // capture / drop
            ST_EVAL: st_d = take ? ST_EVAL : ST_IDLE;  // chain / done
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cap_chan <= '0;
            cap_code <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                cap_chan <= smp_chan;
                cap_code <= smp_code;
            end
        end
    end

    always_comb begin
        eval_en      = (st_q == ST_EVAL);
        req_reset    = req.rst;
        req_poweroff = req.poff;
        req_shutdown = req.shdn;
        healthy      = !req.hlth;
    end

    always_comb begin
        ch_lims = '0;
        for (int c = 0; c < N_CHAN; c++)
            if (cap_chan == CHAN_W'(c))
                for (int k = 0; k < LIM_PER_CH; k++)
                    ch_lims[k] = words[c*LIM_PER_CH + k];
    end

    always_comb begin
        clr_mask = '0;
        if (reg_we && reg_stat_sel) begin
            if (reg_addr == STAT_HI) clr_mask[15:8] = reg_wdata;
            if (reg_addr == STAT_LO) clr_mask[7:0]  = reg_wdata;
        end
    end

    always_comb begin
        if (!reg_stat_sel)            reg_rdata = lim_rdata;
        else if (reg_addr == STAT_HI) reg_rdata = fault[15:8];
        else if (reg_addr == STAT_LO) reg_rdata = fault[7:0];
        else                          reg_rdata = '0;
    end

    slc_limit_bank #(.N_CHAN(N_CHAN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_we && !reg_stat_sel),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (lim_rdata),
        .words (words)
    );

    slc_window_cmp u_cmp (
        .is_temp (cap_chan == CHAN_W'(TEMP_CHAN)),
        .code    (cap_code),
        .lims    (ch_lims),
        .trig    (trig),
        .crit    (crit)
    );

    slc_fault_track #(.N_CHAN(N_CHAN), .CHAN_W(CHAN_W)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval_en  (eval_en),
        .chan     (cap_chan),
        .trig     (trig),
        .crit     (crit),
        .clr_mask (clr_mask),
        .fault    (fault),
        .req      (req)
    );

    AST_EVAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q == ST_EVAL)); // R9
    AST_BAD_CHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && st_q == ST_IDLE) |=> (st_q == ST_IDLE)); // R10
endmodule

// File: tb/supply_limit_cmp_tb.sv
module supply_limit_cmp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [3:0] smp_chan = '0;
    logic [9:0] smp_code = '0;
    logic       reg_we = 1'b0;
    logic       reg_stat_sel = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       req_reset, req_poweroff, req_shutdown, healthy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supply_limit_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_code(smp_code), .reg_we(reg_we), .reg_stat_sel(reg_stat_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_reset(req_reset), .req_poweroff(req_poweroff),
        .req_shutdown(req_shutdown), .healthy(healthy)
    );

    // {chan, code, {rst,healthy,poff,shdn}, status}
    localparam logic [33:0] VEC [15] = '{
        {4'd0,  10'd120,  4'b0000, 16'h0000},  // R3 below non-critical under-limit
        {4'd0,  10'd99,   4'b1000, 16'h0001},  // R3 R5 R7
        {4'd0,  10'd100,  4'b0000, 16'h0001},  // R3 equality
        {4'd0,  10'd500,  4'b0100, 16'h0001},  // R6 inside window
        {4'd0,  10'd901,  4'b0110, 16'h0001},  // R5 over-limit
        {4'd0,  10'd951,  4'b0111, 16'h0001},  // R5 both over-limits
        {4'd0,  10'd950,  4'b0110, 16'h0001},  // R3 equality on over
        {4'd8,  10'd200,  4'b0110, 16'h0001},  // R5 other channel keeps request
        {4'd0,  10'd500,  4'b0100, 16'h0001},  // R5 replaced
        {4'd8,  10'd600,  4'b1100, 16'h0101},  // R4 negative below -40
        {4'd8,  10'd201,  4'b0110, 16'h0101},  // R4 positive over
        {4'd8,  10'd1000, 4'b0100, 16'h0101},  // R4 small negative inside
        {4'd10, 10'd501,  4'b0000, 16'h0101},  // R6 R7 non-critical
        {4'd10, 10'd0,    4'b0100, 16'h0101},  // R6 recovered
        {4'd1,  10'd1023, 4'b0100, 16'h0101}   // R5 zero limits
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit stat, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_stat_sel = stat; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_lim(input int ch, input int k, input logic [15:0] w);
        wr(1'b0, 8'(8'h80 + ch*8 + k*2), w[15:8]);
        wr(1'b0, 8'(8'h80 + ch*8 + k*2 + 1), w[7:0]);
    endtask

    task automatic rd(input bit stat, input logic [7:0] a, output logic [7:0] d);
        reg_stat_sel = stat; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_stat(output logic [15:0] s);
        logic [7:0] hi, lo;
        rd(1'b1, 8'h81, hi);
        rd(1'b1, 8'h82, lo);
        s = {hi, lo};
    endtask

    task automatic sample(input logic [3:0] ch, input logic [9:0] code);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = ch; smp_code = code;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [3:0] outs();
        return {req_reset, healthy, req_poweroff, req_shutdown};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(outs() == 4'b0100, "R1 outputs", outs(), 4'b0100);
        rd_stat(s);
        chk(s == 16'h0, "R1 status", s, 0);
        rd(1'b0, 8'h80, b);
        chk(b == 8'h0, "R1 limit", b, 0);

        wr_lim(0, 0, 16'h8000 | 16'd100);
        wr_lim(0, 1, 16'h4000 | 16'd150);
        wr_lim(0, 2, 16'h2000 | 16'd900);
        wr_lim(0, 3, 16'h1000 | 16'd950);
        wr_lim(8, 0, 16'h8000 | 16'd984);
        wr_lim(8, 2, 16'h2000 | 16'd200);
        wr_lim(10, 3, 16'h4000 | 16'd500);

        // R2 readback and address map
        rd(1'b0, 8'h80, b); chk(b == 8'h80, "R2 ch0 lim0 hi", b, 8'h80);
        rd(1'b0, 8'h81, b); chk(b == 8'h64, "R2 ch0 lim0 lo", b, 8'h64);
        rd(1'b0, 8'h82, b); chk(b == 8'h40, "R2 ch0 lim1 hi", b, 8'h40);
        rd(1'b0, 8'h83, b); chk(b == 8'h96, "R2 ch0 lim1 lo", b, 8'h96);
        rd(1'b0, 8'hD6, b); chk(b == 8'h41, "R2 ch10 lim3 hi", b, 8'h41);
        rd(1'b0, 8'hD8, b); chk(b == 8'h00, "R2 out of range", b, 0);

        for (int i = 0; i < 15; i++) begin
            sample(VEC[i][33:30], VEC[i][29:20]);
            chk(outs() == VEC[i][19:16], $sformatf("R5 vec%0d outputs", i), outs(), VEC[i][19:16]);
            rd_stat(s);
            chk(s == VEC[i][15:0], $sformatf("R7 vec%0d status", i), s, VEC[i][15:0]);
        end

        // R8 write-one-to-clear per byte
        wr(1'b1, 8'h82, 8'h01);
        rd_stat(s); chk(s == 16'h0100, "R8 clear low byte", s, 16'h0100);
        wr(1'b1, 8'h81, 8'h01);
        rd_stat(s); chk(s == 16'h0000, "R8 clear high byte", s, 0);

        // R9 latency, then R8 set wins over a same-edge clear
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'd0; smp_code = 10'd99;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(req_reset == 1'b0, "R9 not before eval edge", req_reset, 0);
        reg_we = 1'b1; reg_stat_sel = 1'b1; reg_addr = 8'h82; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
        chk(req_reset == 1'b1, "R9 at eval edge", req_reset, 1);
        rd_stat(s); chk(s == 16'h0001, "R8 set wins", s, 16'h0001);

        // R10 out-of-range channels dropped
        sample(4'd11, 10'd500);
        sample(4'd15, 10'd500);
        chk(outs() == 4'b1000, "R10 outputs unchanged", outs(), 4'b1000);
        rd_stat(s); chk(s == 16'h0001, "R10 status unchanged", s, 16'h0001);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 4'b0100, "R1 outputs after reset", outs(), 4'b0100);
        rd_stat(s); chk(s == 16'h0, "R1 status after reset", s, 0);
        rd(1'b0, 8'h80, b); chk(b == 8'h0, "R1 limit after reset", b, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule